// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Pinned Entries

This block is a small, fully associative cache of address translations. Each entry holds a virtual page number, an address-space tag, a physical frame number, three permission bits, a valid bit and a pinned bit. A lookup compares the presented page number and address-space tag against every entry at once. In the same cycle it reports a hit or a miss, the frame number and whether the requested kind of access is allowed. Because every entry carries its own address-space tag, switching between processes needs no flush.

After a miss, the page-table walker outside this block writes the recovered translation through the fill port. If the fill key already exists, the matching entry is rewritten in place. Otherwise a round-robin pointer picks the victim, skipping pinned entries. When every entry is pinned, a fill that needs a new slot is dropped and `fill_err` flags it in that cycle. Software can also pin or unpin a single slot, drop every unpinned entry, or drop the unpinned entries of one address space.

Each cycle the control logic decodes exactly one update operation, held in an enumerated state:
- OP_IDLE: no update.
- OP_FLUSH_ALL: clear every unpinned entry.
- OP_FLUSH_ASID: clear the unpinned entries of one address space.
- OP_PIN: set or clear one pinned bit.
- OP_FILL: write a translation.

The transitions from one cycle to the next follow a fixed priority: OP_FLUSH_ALL, then OP_FLUSH_ASID, then OP_PIN, then OP_FILL, and OP_IDLE when no request is raised. Every operation takes effect at the clock edge that ends its cycle.

Top module: `asid_tlb`

## Requirements
- R1: With `lk_valid` high, `lk_hit` rises in the same cycle when a valid entry holds both `lk_vpn` and `lk_asid`, and `lk_pfn` then shows that entry's frame. Otherwise `lk_miss` rises and `lk_pfn` is 0. With `lk_valid` low, `lk_hit`, `lk_miss` and `lk_fault` are all 0.
- R2: An entry with the same page number but a different address-space tag does not hit. Two address spaces may hold the same page number at once, each with its own frame.
- R3: After reset every entry is invalid and unpinned, and the round-robin pointer is at slot 0. An invalid entry never hits.
- R4: After an accepted fill, a lookup of the same key in the next cycle hits and returns the filled frame.
- R5: A fill whose key matches a valid entry rewrites that entry's frame and permissions in place. It leaves the round-robin pointer unchanged and creates no second copy.
- R6: A fill of a new key is written to the first unpinned slot at or after the round-robin pointer, searching upward and wrapping. The pointer then moves to the slot after the victim, wrapping from N-1 to 0.
- R7: A pinned slot is never chosen as a victim. When all slots are pinned and the fill key is new, the fill is dropped and `fill_err` is 1 in that cycle. In every other cycle `fill_err` is 0.
- R8: `flush_all` makes every unpinned entry invalid at the next edge. Pinned entries keep their contents.
- R9: `flush_asid_en` makes invalid every unpinned entry whose tag equals `flush_asid`. Entries with other tags, and pinned entries, are kept.
- R10: Permission bits are bit0 = read, bit1 = write and bit2 = execute. The access codes are `lk_acc` 0 = read, 1 = write, and 2 or 3 = execute. On a hit where the bit selected by the access code is 0, `lk_fault` is 1. A miss never sets `lk_fault`.
- R11: When several update requests arrive in one cycle, only the one with the highest priority acts. The order is flush_all, then the address-space flush, then pin, then fill. A fill held back this way leaves no entry behind.
- R12: When more than one entry matches, the lowest slot index supplies the result and `lk_multi` is 1. Fills never create duplicates, so `lk_multi` stays 0 in normal use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2/3 execute |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_miss | output | 1 | Lookup found no matching entry |
| lk_pfn | output | PFN_W | Frame number on a hit, else 0 |
| lk_fault | output | 1 | Hit but the access is not permitted |
| lk_multi | output | 1 | More than one entry matched |
| fill_valid | input | 1 | Fill request |
| fill_vpn | input | VPN_W | Fill page number |
| fill_asid | input | ASID_W | Fill address-space tag |
| fill_pfn | input | PFN_W | Fill frame number |
| fill_perm | input | 3 | Fill permissions: bit0 read, bit1 write, bit2 execute |
| fill_err | output | 1 | Fill dropped because every slot is pinned |
| pin_en | input | 1 | Pin-update request |
| pin_idx | input | IDX_W | Slot whose pinned bit is written |
| pin_set | input | 1 | New value of the pinned bit |
| flush_all | input | 1 | Invalidate all unpinned entries |
| flush_asid_en | input | 1 | Invalidate unpinned entries of one tag |
| flush_asid | input | ASID_W | Tag for the per-space flush |

## Verification
Several properties are checked on every cycle:
- a fill is followed by a hit on the same key;
- the chosen victim is never a pinned slot;
- `fill_err` appears only while every slot is pinned;
- no unpinned entry survives a global flush, and none with the flushed tag survives a per-space flush;
- a fault implies a hit;
- no multiple match ever arises.

Only the bench scenarios show the exact slot a victim lands in, the eviction order after the pointer wraps, and that a rewrite in place leaves the pointer alone. They also show that a fill held back by a flush in the same cycle leaves no trace, and that each access kind is checked against the right permission bit.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_FLUSH_ALL,
        OP_FLUSH_ASID,
        OP_PIN,
        OP_FILL
    } op_t;

    localparam int PERM_BITS = 3;
    localparam int PB_READ   = 0;
    localparam int PB_WRITE  = 1;
    localparam int PB_EXEC   = 2;

    // Picks the permission bit that the access kind needs.
    function automatic logic perm_allows(input logic [PERM_BITS-1:0] perm,
                                         input logic [1:0] acc);
        logic ok;
        unique case (acc)
            2'd0:    ok = perm[PB_READ];
            2'd1:    ok = perm[PB_WRITE];
            default: ok = perm[PB_EXEC];
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N      = 16,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]             ent_valid,
    input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [N-1:0][ASID_W-1:0] ent_asid,
    input  logic [VPN_W-1:0]         key_vpn,
    input  logic [ASID_W-1:0]        key_asid,
    output logic                     hit,
    output logic [IDX_W-1:0]         idx,
    output logic                     multi
);

    logic [N-1:0] match;

    // One comparator per slot, all working at the same time.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = ent_valid[g] && (ent_vpn[g] == key_vpn)
                          && (ent_asid[g] == key_asid);
    end

    // Priority encoder: the lowest matching slot wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    always_comb begin
        int cnt;
        cnt = 0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) cnt++;
        end
        multi = (cnt > 1);
    end

    assign hit = |match;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N      = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [IDX_W-1:0] ptr,
    input  logic [N-1:0]     wired,
    output logic             found,
    output logic [IDX_W-1:0] victim,
    output logic [IDX_W-1:0] next_ptr
);

    // Search upward from the pointer, wrapping, and take the first unpinned slot.
    always_comb begin
        found  = 1'b0;
        victim = '0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = (int'(ptr) + k) % N;
            if (!found && !wired[c]) begin
                found  = 1'b1;
                victim = IDX_W'(c);
            end
        end
    end

    assign next_ptr = (int'(victim) == N - 1) ? '0 : IDX_W'(int'(victim) + 1);

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter int N      = 16,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [1:0]        lk_acc,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic              lk_fault,
    output logic              lk_multi,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [2:0]        fill_perm,
    output logic              fill_err,
    input  logic              pin_en,
    input  logic [IDX_W-1:0]  pin_idx,
    input  logic              pin_set,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid
);

    logic [N-1:0]                ent_valid;
    logic [N-1:0]                ent_wired;
    logic [N-1:0][VPN_W-1:0]     ent_vpn;
    logic [N-1:0][ASID_W-1:0]    ent_asid;
    logic [N-1:0][PFN_W-1:0]     ent_pfn;
    logic [N-1:0][PERM_BITS-1:0] ent_perm;
    logic [IDX_W-1:0]            rr_ptr;

    op_t              op;
    logic             m_hit, m_multi, f_hit, f_multi_unused;
    logic [IDX_W-1:0] m_idx, f_idx;
    logic             vic_found;
    logic [IDX_W-1:0] vic_idx, vic_next;

    // Lookup-side comparator array.
    tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lookup (
        .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_asid(ent_asid),
        .key_vpn(lk_vpn), .key_asid(lk_asid),
        .hit(m_hit), .idx(m_idx), .multi(m_multi)
    );

    // Fill-side comparator array, used to find a rewrite in place.
    tlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fillchk (
        .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_asid(ent_asid),
        .key_vpn(fill_vpn), .key_asid(fill_asid),
        .hit(f_hit), .idx(f_idx), .multi(f_multi_unused)
    );

    tlb_victim #(.N(N)) u_victim (
        .ptr(rr_ptr), .wired(ent_wired),
        .found(vic_found), .victim(vic_idx), .next_ptr(vic_next)
    );

    // Operation decode, in priority order.
    always_comb begin
        if (flush_all)          op = OP_FLUSH_ALL;
        else if (flush_asid_en) op = OP_FLUSH_ASID;
        else if (pin_en)        op = OP_PIN;
        else if (fill_valid)    op = OP_FILL;
        else                    op = OP_IDLE;
    end

    // State register: entry storage and round-robin pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_wired <= '0;
            ent_vpn   <= '0;
            ent_asid  <= '0;
            ent_pfn   <= '0;
            ent_perm  <= '0;
            rr_ptr    <= '0;
        end else begin
            unique case (op)
                OP_IDLE: ;
                OP_FLUSH_ALL: ent_valid <= ent_valid & ent_wired;
                OP_FLUSH_ASID: begin
                    for (int i = 0; i < N; i++) begin
                        if (!ent_wired[i] && ent_asid[i] == flush_asid)
                            ent_valid[i] <= 1'b0;
                    end
                end
                OP_PIN: ent_wired[pin_idx] <= pin_set;
                OP_FILL: begin
                    if (f_hit) begin
                        ent_pfn[f_idx]  <= fill_pfn;
                        ent_perm[f_idx] <= fill_perm;
                    end else if (vic_found) begin
                        ent_valid[vic_idx] <= 1'b1;
                        ent_vpn[vic_idx]   <= fill_vpn;
                        ent_asid[vic_idx]  <= fill_asid;
                        ent_pfn[vic_idx]   <= fill_pfn;
                        ent_perm[vic_idx]  <= fill_perm;
                        rr_ptr             <= vic_next;
                    end
                end
            endcase
        end
    end

    // Outputs.
    always_comb begin
        lk_hit   = lk_valid && m_hit;
        lk_miss  = lk_valid && !m_hit;
        lk_pfn   = lk_hit ? ent_pfn[m_idx] : '0;
        lk_fault = lk_hit && !perm_allows(ent_perm[m_idx], lk_acc);
        lk_multi = lk_valid && m_multi;
        fill_err = (op == OP_FILL) && !f_hit && !vic_found;
    end

    assert_fill_then_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FILL && !fill_err) |=>
        (!(lk_valid && lk_vpn == $past(fill_vpn) && lk_asid == $past(fill_asid)) || lk_hit));

    assert_victim_unpinned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FILL && !f_hit && vic_found) |-> !ent_wired[vic_idx]);

    assert_err_needs_all_pinned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_err |-> (&ent_wired));

    assert_flush_all_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> ((ent_valid & ~ent_wired) == '0));

    for (genvar g = 0; g < N; g++) begin : g_flush_chk
        assert_asid_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!flush_all && flush_asid_en && !ent_wired[g] && ent_asid[g] == flush_asid)
            |=> !ent_valid[g]);
    end

    assert_fault_needs_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);

    assert_no_duplicate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> !lk_multi);

endmodule

// File: tb/asid_tlb_test.sv
module asid_tlb_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16, VPN_W = 20, ASID_W = 8, PFN_W = 16, IDX_W = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_valid = 0, fill_valid = 0, pin_en = 0, pin_set = 0;
    logic flush_all = 0, flush_asid_en = 0;
    logic [VPN_W-1:0] lk_vpn = 0, fill_vpn = 0;
    logic [ASID_W-1:0] lk_asid = 0, fill_asid = 0, flush_asid = 0;
    logic [1:0] lk_acc = 0;
    logic [PFN_W-1:0] fill_pfn = 0;
    logic [2:0] fill_perm = 0;
    logic [IDX_W-1:0] pin_idx = 0;
    logic lk_hit, lk_miss, lk_fault, lk_multi, fill_err;
    logic [PFN_W-1:0] lk_pfn;

    int compared = 0, mismatched = 0;

    // Behavioural model of the table.
    bit m_v[N], m_w[N];
    int m_vpn[N], m_asid[N], m_pfn[N], m_perm[N];
    int m_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    asid_tlb uut (.*);

    task automatic chk(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int find(int vpn, int asid);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) return i;
        return -1;
    endfunction

    function automatic int pick_victim();
        for (int k = 0; k < N; k++)
            if (!m_w[(m_ptr + k) % N]) return (m_ptr + k) % N;
        return -1;
    endfunction

    task automatic tick(string tag);
        int e, ok, ehit, d, v;
        #2;
        e = find(lk_vpn, lk_asid);
        ehit = (lk_valid && e >= 0) ? 1 : 0;
        ok = 0;
        if (e >= 0) ok = (lk_acc == 0) ? m_perm[e] & 1 : (lk_acc == 1) ? (m_perm[e] >> 1) & 1 : (m_perm[e] >> 2) & 1;
        chk(tag, "hit", int'(lk_hit), ehit);
        chk(tag, "miss", int'(lk_miss), (lk_valid && e < 0) ? 1 : 0);
        chk(tag, "pfn", int'(lk_pfn), ehit ? m_pfn[e] : 0);
        chk(tag, "fault", int'(lk_fault), (ehit && !ok) ? 1 : 0);
        chk(tag, "multi", int'(lk_multi), 0);
        d = find(fill_vpn, fill_asid);
        v = pick_victim();
        chk(tag, "fill_err", int'(fill_err),
            (!flush_all && !flush_asid_en && !pin_en && fill_valid && d < 0 && v < 0) ? 1 : 0);
        @(posedge clk);
        if (flush_all) begin
            for (int i = 0; i < N; i++) if (!m_w[i]) m_v[i] = 0;
        end else if (flush_asid_en) begin
            for (int i = 0; i < N; i++) if (!m_w[i] && m_asid[i] == flush_asid) m_v[i] = 0;
        end else if (pin_en) begin
            m_w[pin_idx] = pin_set;
        end else if (fill_valid) begin
            if (d >= 0) begin
                m_pfn[d] = fill_pfn; m_perm[d] = fill_perm;
            end else if (v >= 0) begin
                m_v[v] = 1; m_vpn[v] = fill_vpn; m_asid[v] = fill_asid;
                m_pfn[v] = fill_pfn; m_perm[v] = fill_perm; m_ptr = (v + 1) % N;
            end
        end
        @(negedge clk);
        lk_valid = 0; fill_valid = 0; pin_en = 0; flush_all = 0; flush_asid_en = 0;
    endtask

    task automatic look(int vpn, int asid, int acc, string tag);
        lk_valid = 1; lk_vpn = VPN_W'(vpn); lk_asid = ASID_W'(asid); lk_acc = 2'(acc);
        tick(tag);
    endtask

    task automatic fill(int vpn, int asid, int pfn, int perm, string tag);
        fill_valid = 1; fill_vpn = VPN_W'(vpn); fill_asid = ASID_W'(asid);
        fill_pfn = PFN_W'(pfn); fill_perm = 3'(perm);
        tick(tag);
    endtask

    task automatic pin(int idx, int val, string tag);
        pin_en = 1; pin_idx = IDX_W'(idx); pin_set = 1'(val);
        tick(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_w[i] = 0; m_vpn[i] = 0; m_asid[i] = 0; m_pfn[i] = 0; m_perm[i] = 0;
        end
        m_ptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R3: empty after reset; idle lookup gives nothing (R1)
        look(5, 1, 0, "R3");
        tick("R1");
        // R1 R4: fills then hits
        for (int i = 0; i < 4; i++) begin
            fill(16 + i, 1, 100 + i, 3, "R4");
            look(16 + i, 1, 0, "R4");
        end
        look(99, 1, 0, "R1");
        // R2: same page, other space
        look(16, 2, 0, "R2");
        fill(16, 2, 555, 7, "R2");
        look(16, 2, 0, "R2");
        look(16, 1, 0, "R2");
        // R10: permissions
        fill(40, 3, 40, 1, "R10");
        look(40, 3, 1, "R10");
        look(40, 3, 0, "R10");
        fill(41, 3, 41, 4, "R10");
        look(41, 3, 0, "R10");
        look(41, 3, 2, "R10");
        look(41, 3, 3, "R10");
        look(16, 2, 1, "R10");
        // R5: rewrite in place
        fill(17, 1, 777, 1, "R5");
        look(17, 1, 1, "R5");
        look(17, 1, 0, "R12");
        // R6: wrap the pointer and evict oldest
        for (int i = 0; i < 12; i++) fill(200 + i, 4, 200 + i, 7, "R6");
        look(16, 1, 0, "R6");
        look(17, 1, 0, "R6");
        look(211, 4, 0, "R6");
        // R7: pinned slots survive eviction
        pin(2, 1, "R7");
        pin(3, 1, "R7");
        for (int i = 0; i < 18; i++) fill(300 + i, 5, 300 + i, 7, "R7");
        look(18, 1, 0, "R7");
        look(19, 1, 0, "R7");
        look(300, 5, 0, "R6");
        // R7: all pinned
        for (int i = 0; i < N; i++) pin(i, 1, "R7");
        fill(900, 6, 9, 7, "R7");
        look(900, 6, 0, "R7");
        fill(18, 1, 1234, 7, "R5");
        look(18, 1, 0, "R5");
        for (int i = 0; i < N; i++) pin(i, 0, "R7");
        // R9: per-space flush
        fill(500, 8, 50, 7, "R9");
        fill(500, 9, 51, 7, "R9");
        fill(501, 8, 52, 7, "R9");
        pin(find(501, 8), 1, "R9");
        flush_asid_en = 1; flush_asid = 8; tick("R9");
        look(500, 8, 0, "R9");
        look(500, 9, 0, "R9");
        look(501, 8, 0, "R9");
        // R11: flush beats fill in the same cycle
        flush_all = 1; fill_valid = 1; fill_vpn = 600; fill_asid = 1;
        fill_pfn = 60; fill_perm = 7; tick("R11");
        look(600, 1, 0, "R11");
        // R8: global flush kept pinned entry
        look(500, 9, 0, "R8");
        look(501, 8, 0, "R8");
        pin(find(501, 8), 0, "R8");
        flush_all = 1; tick("R8");
        look(501, 8, 0, "R8");
        // R11: pin beats fill
        pin_en = 1; pin_idx = 0; pin_set = 0; fill_valid = 1; fill_vpn = 700; fill_asid = 2;
        tick("R11");
        look(700, 2, 0, "R11");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule